// File: doc/BRIEF.md
# Serial Page-Flash Command Sequencer

This block is the SPI master that sits between a simple single-request port and a page-organised serial flash device. The device has 512 pages of 264 bytes and one 264-byte SRAM staging buffer. A request names an operation, a page number, a byte offset and one byte of write data. The sequencer turns it into a byte-aligned serial frame on chip select, clock and data-out. For reads it captures the returned byte from data-in. For operations the device completes on its own, it raises chip select straight after the last command bit and then polls the device status until the device reports ready. The request port is answered with a single-cycle `done` and, for reads, the captured byte.

At start-up the sequencer reads the status register once and compares its density field with the expected code. It raises a sticky flag when the field differs. The serial clock rate is set by a half-period divider. The clock idle level is a parameter: low gives SPI mode 0 and high gives mode 3. In both modes data-out changes on the falling clock edge and is sampled by the device on the rising edge.

The control FSM has five states. `ST_GAP` keeps chip select high for the inter-frame gap; reset enters it. `ST_LAUNCH` drops chip select and starts the shifter. `ST_SHIFT` waits for the frame to finish. `ST_IDLE` accepts requests. `ST_DONE` pulses `done`. The transitions are:
- `ST_IDLE`→`ST_LAUNCH` when a request is accepted.
- `ST_LAUNCH`→`ST_SHIFT` unconditionally.
- `ST_SHIFT`→`ST_GAP` at frame end.
- `ST_GAP`→ the stored return state once the gap expires: `ST_IDLE` after the boot check, `ST_LAUNCH` for another status poll, or `ST_DONE` when the request has finished.
- `ST_DONE`→`ST_IDLE` unconditionally.

A frame-kind register (boot check, command, poll) decides how the end of each frame is handled.

Top module: `dflash_cmd_ctrl`

## Requirements
- R1: During and after reset, `spi_cs_n` is high, `spi_sck` is at its idle level and `req_ready` and `done` are low. The first frame after reset is a 16-bit status read using opcode `OPC_STATUS`. `req_ready` rises only after that frame and its chip-select gap.
- R2: `err_density` is set after the boot status read when status bits 5:3 differ from `DENSITY_CODE` (default 3'b001), and is cleared otherwise. It keeps its value until the next reset.
- R3: `req_op` codes are: 0 direct page read, 1 buffer read, 2 buffer write, 3 page-to-buffer transfer, 4 buffer-to-page program with erase, 5 page erase, 6 block erase, 7 status read. Every non-status frame sends an 8-bit opcode followed by a 24-bit address, both MSB first. The address is six zero bits, then the 9-bit page, then the 9-bit byte offset.
- R4: A direct page read uses opcode 0x52, then 32 don't-care bits after the address. The 72-bit frame's final 8 bits are captured into `rd_data`.
- R5: A buffer read uses opcode 0x54 with 8 don't-care bits after the address and captures the final 8 bits of a 48-bit frame. A buffer write uses opcode `OPC_BUF_WR` (default 0x84) and sends `req_wdata` as bits 32..39 of a 40-bit frame.
- R6: The self-timed operations send a 32-bit frame: page-to-buffer uses 0x53, program uses `OPC_PROG` (default 0x83), page erase uses 0x81 and block erase uses 0x50. Chip select rises right after the 32nd bit.
- R7: After a self-timed frame, 16-bit status frames are repeated until a returned status has bit 7 = 1. `done` follows the first ready status.
- R8: If `POLL_LIMIT` status polls all return bit 7 = 0, polling stops and `err_timeout` is 1 when `done` pulses. `err_timeout` is cleared when the next request is accepted.
- R9: Between any two frames, `spi_cs_n` stays high for at least `CS_GAP` clock cycles.
- R10: Within a frame, each bit spends `DIV_HALF` clocks with SCK low and then `DIV_HALF` clocks with SCK high. Every frame is a multiple of 8 bits. While chip select is high, SCK sits at `SCK_IDLE_HIGH` (0 = mode 0, 1 = mode 3).
- R11: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_valid` at any other time starts no frame.
- R12: `done` is high for exactly one clock per accepted request.
- R13: A status-read request (code 7) returns the device status byte in `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R3) |
| req_page | input | 9 | Page number |
| req_byte | input | 9 | Byte offset within page or buffer |
| req_wdata | input | 8 | Byte for buffer write |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read request |
| err_timeout | output | 1 | Status polling gave up |
| err_density | output | 1 | Boot density field mismatch |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bench builds the block with `DIV_HALF` = 2, `CS_GAP` = 3, `POLL_LIMIT` = 6 and mode 0. With these values a full 72-bit page read lasts a few hundred clocks, so dozens of mixed random and directed requests fit in one run. The small poll limit means a device model that stays busy for a hundred polls triggers the timeout after six status frames. The model's busy count is chosen per request, which covers ready on the first poll, ready after several polls, and no ready at all. A second reset with a wrong density field exercises the boot check.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    localparam int CMD_BITS   = 8;
    localparam int PAGE_W     = 9;
    localparam int BYTE_W     = 9;
    localparam int ADDR_BITS  = 24;
    localparam int RSVD_W     = ADDR_BITS - PAGE_W - BYTE_W;
    localparam int DATA_BITS  = 8;
    localparam int PRD_DUMMY  = 32;
    localparam int BRD_DUMMY  = 8;
    localparam int TX_W       = CMD_BITS + ADDR_BITS + DATA_BITS;
    localparam int NB_W       = 7;

    localparam int NB_STATUS  = CMD_BITS + DATA_BITS;
    localparam int NB_TIMED   = CMD_BITS + ADDR_BITS;
    localparam int NB_BUF_WR  = CMD_BITS + ADDR_BITS + DATA_BITS;
    localparam int NB_BUF_RD  = CMD_BITS + ADDR_BITS + BRD_DUMMY + DATA_BITS;
    localparam int NB_PAGE_RD = CMD_BITS + ADDR_BITS + PRD_DUMMY + DATA_BITS;

    localparam logic [7:0] OPC_PAGE_RD     = 8'h52;
    localparam logic [7:0] OPC_BUF_RD      = 8'h54;
    localparam logic [7:0] OPC_PAGE_TO_BUF = 8'h53;
    localparam logic [7:0] OPC_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OPC_BLOCK_ERASE = 8'h50;

    typedef enum logic [2:0] {
        OP_PAGE_RD     = 3'd0,
        OP_BUF_RD      = 3'd1,
        OP_BUF_WR      = 3'd2,
        OP_PAGE_TO_BUF = 3'd3,
        OP_BUF_TO_PAGE = 3'd4,
        OP_PAGE_ERASE  = 3'd5,
        OP_BLOCK_ERASE = 3'd6,
        OP_STATUS      = 3'd7
    } dfc_op_e;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_LAUNCH,
        ST_SHIFT,
        ST_IDLE,
        ST_DONE
    } dfc_state_e;

    typedef enum logic [1:0] {
        K_BOOT,
        K_CMD,
        K_POLL
    } dfc_kind_e;

endpackage

// File: rtl/dfc_frame_build.sv
module dfc_frame_build
    import dfc_pkg::*;
#(
    parameter logic [7:0] OPC_PROG   = 8'h83,
    parameter logic [7:0] OPC_BUF_WR = 8'h84,
    parameter logic [7:0] OPC_STATUS = 8'hD7
) (
    input  dfc_op_e            op,
    input  logic [PAGE_W-1:0]  page,
    input  logic [BYTE_W-1:0]  offs,
    input  logic [7:0]         wdata,
    output logic [TX_W-1:0]    tx_word,
    output logic [NB_W-1:0]    nbits,
    output logic               captures,
    output logic               self_timed
);

    logic [7:0] opc;

    always_comb begin
        opc        = OPC_STATUS;
        nbits      = NB_W'(NB_STATUS);
        captures   = 1'b0;
        self_timed = 1'b0;
        unique case (op)
            OP_PAGE_RD: begin
                opc = OPC_PAGE_RD;
                nbits = NB_W'(NB_PAGE_RD);
                captures = 1'b1;
            end
            OP_BUF_RD: begin
                opc = OPC_BUF_RD;
                nbits = NB_W'(NB_BUF_RD);
                captures = 1'b1;
            end
            OP_BUF_WR: begin
                opc = OPC_BUF_WR;
                nbits = NB_W'(NB_BUF_WR);
            end
            OP_PAGE_TO_BUF: begin
                opc = OPC_PAGE_TO_BUF;
                nbits = NB_W'(NB_TIMED);
                self_timed = 1'b1;
            end
            OP_BUF_TO_PAGE: begin
                opc = OPC_PROG;
                nbits = NB_W'(NB_TIMED);
                self_timed = 1'b1;
            end
            OP_PAGE_ERASE: begin
                opc = OPC_PAGE_ERASE;
                nbits = NB_W'(NB_TIMED);
                self_timed = 1'b1;
            end
            OP_BLOCK_ERASE: begin
                opc = OPC_BLOCK_ERASE;
                nbits = NB_W'(NB_TIMED);
                self_timed = 1'b1;
            end
            OP_STATUS: begin
                opc = OPC_STATUS;
                nbits = NB_W'(NB_STATUS);
                captures = 1'b1;
            end
        endcase
    end

    // Address bits trail the opcode; status frames carry no address.
    assign tx_word = (op == OP_STATUS) ? {opc, {(TX_W-CMD_BITS){1'b0}}}
                                       : {opc, {RSVD_W{1'b0}}, page, offs, wdata};

endmodule

// File: rtl/dfc_spi_shift.sv
module dfc_spi_shift
    import dfc_pkg::*;
#(
    parameter int   DIV_HALF      = 4,
    parameter logic SCK_IDLE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TX_W-1:0]  tx_word,
    input  logic [NB_W-1:0]  nbits,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx_byte
);

    localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);

    logic              busy_q;
    logic              ph_q;
    logic [DIV_W-1:0]  div_q;
    logic [NB_W-1:0]   cnt_q;
    logic [TX_W-1:0]   tx_q;
    logic [7:0]        rx_q;
    logic              done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ph_q   <= 1'b0;
            div_q  <= '0;
            cnt_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    ph_q   <= 1'b0;
                    div_q  <= '0;
                    cnt_q  <= nbits;
                    tx_q   <= tx_word;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!ph_q) begin
                    ph_q <= 1'b1;
                    rx_q <= {rx_q[6:0], miso};
                end else begin
                    ph_q  <= 1'b0;
                    tx_q  <= {tx_q[TX_W-2:0], 1'b0};
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == NB_W'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sck     = busy_q ? ph_q : SCK_IDLE_HIGH;
    assign mosi    = tx_q[TX_W-1];
    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_byte = rx_q;

    assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
    assert_len_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0));
    assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

endmodule

// File: rtl/dflash_cmd_ctrl.sv
module dflash_cmd_ctrl
    import dfc_pkg::*;
#(
    parameter int         DIV_HALF      = 4,
    parameter logic       SCK_IDLE_HIGH = 1'b0,
    parameter int         CS_GAP        = 8,
    parameter int         POLL_LIMIT    = 4000,
    parameter logic [7:0] OPC_PROG      = 8'h83,
    parameter logic [7:0] OPC_BUF_WR    = 8'h84,
    parameter logic [7:0] OPC_STATUS    = 8'hD7,
    parameter logic [2:0] DENSITY_CODE  = 3'b001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_op,
    input  logic [8:0]  req_page,
    input  logic [8:0]  req_byte,
    input  logic [7:0]  req_wdata,
    output logic        req_ready,
    output logic        done,
    output logic [7:0]  rd_data,
    output logic        err_timeout,
    output logic        err_density,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    localparam int GAP_W  = $clog2(CS_GAP + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(CS_GAP - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

    dfc_state_e         state_q, state_d;
    dfc_state_e         gap_ret_q;
    dfc_kind_e          kind_q;
    dfc_op_e            op_q;
    logic [PAGE_W-1:0]  page_q;
    logic [BYTE_W-1:0]  byte_q;
    logic [7:0]         wdata_q;
    logic [GAP_W-1:0]   gap_cnt_q;
    logic [POLL_W-1:0]  poll_cnt_q;
    logic [7:0]         rd_data_q;
    logic               err_to_q;
    logic               err_dens_q;

    dfc_op_e            fb_op;
    logic [TX_W-1:0]    fb_tx;
    logic [NB_W-1:0]    fb_nbits;
    logic               fb_captures;
    logic               fb_timed;

    logic               sh_start;
    logic               sh_busy;
    logic               sh_done;
    logic [7:0]         sh_rx;

    assign fb_op = (kind_q == K_CMD) ? op_q : OP_STATUS;

    dfc_frame_build #(
        .OPC_PROG   (OPC_PROG),
        .OPC_BUF_WR (OPC_BUF_WR),
        .OPC_STATUS (OPC_STATUS)
    ) frame_i (
        .op         (fb_op),
        .page       (page_q),
        .offs       (byte_q),
        .wdata      (wdata_q),
        .tx_word    (fb_tx),
        .nbits      (fb_nbits),
        .captures   (fb_captures),
        .self_timed (fb_timed)
    );

    dfc_spi_shift #(
        .DIV_HALF      (DIV_HALF),
        .SCK_IDLE_HIGH (SCK_IDLE_HIGH)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_word (fb_tx),
        .nbits   (fb_nbits),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_SHIFT;
            ST_SHIFT:  if (sh_done) state_d = ST_GAP;
            ST_GAP:    if (gap_cnt_q == GAP_LAST) state_d = gap_ret_q;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GAP;
        else        state_q <= state_d;
    end

    // Frame context, counters and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_ret_q  <= ST_LAUNCH;
            kind_q     <= K_BOOT;
            op_q       <= OP_STATUS;
            page_q     <= '0;
            byte_q     <= '0;
            wdata_q    <= '0;
            gap_cnt_q  <= '0;
            poll_cnt_q <= '0;
            rd_data_q  <= '0;
            err_to_q   <= 1'b0;
            err_dens_q <= 1'b0;
        end else begin
            gap_cnt_q <= (state_q == ST_GAP) ? gap_cnt_q + 1'b1 : '0;
            if (state_q == ST_IDLE && req_valid) begin
                kind_q     <= K_CMD;
                op_q       <= dfc_op_e'(req_op);
                page_q     <= req_page;
                byte_q     <= req_byte;
                wdata_q    <= req_wdata;
                poll_cnt_q <= '0;
                err_to_q   <= 1'b0;
            end
            if (state_q == ST_SHIFT && sh_done) begin
                unique case (kind_q)
                    K_BOOT: begin
                        err_dens_q <= (sh_rx[5:3] != DENSITY_CODE);
                        gap_ret_q  <= ST_IDLE;
                    end
                    K_CMD: begin
                        if (fb_captures) rd_data_q <= sh_rx;
                        if (fb_timed) begin
                            kind_q    <= K_POLL;
                            gap_ret_q <= ST_LAUNCH;
                        end else begin
                            gap_ret_q <= ST_DONE;
                        end
                    end
                    K_POLL: begin
                        poll_cnt_q <= poll_cnt_q + 1'b1;
                        if (sh_rx[7]) begin
                            gap_ret_q <= ST_DONE;
                        end else if (poll_cnt_q == POLL_LAST) begin
                            err_to_q  <= 1'b1;
                            gap_ret_q <= ST_DONE;
                        end else begin
                            gap_ret_q <= ST_LAUNCH;
                        end
                    end
                    default: gap_ret_q <= ST_DONE;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_DONE);
        sh_start  = (state_q == ST_LAUNCH);
        spi_cs_n  = !((state_q == ST_LAUNCH) || (state_q == ST_SHIFT));
    end

    assign rd_data     = rd_data_q;
    assign err_timeout = err_to_q;
    assign err_density = err_dens_q;

    // Chip-select high-time tracker for the gap check
    logic [GAP_W-1:0] cs_hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cs_hi_q <= '0;
        else if (!spi_cs_n)          cs_hi_q <= '0;
        else if (cs_hi_q != GAP_W'(CS_GAP)) cs_hi_q <= cs_hi_q + 1'b1;
    end

    assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (cs_hi_q == GAP_W'(CS_GAP)));
    assert_sck_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_sck == SCK_IDLE_HIGH));
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && !sh_busy));
    assert_clear_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !err_timeout);
    assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt_q <= POLL_W'(POLL_LIMIT));

endmodule

// File: tb/dflash_cmd_ctrl_tb.sv
module dflash_cmd_ctrl_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         DIV        = 2;
    localparam int         GAP        = 3;
    localparam int         PLIM       = 6;
    localparam logic [7:0] PROG       = 8'h83;
    localparam logic [7:0] BUFWR      = 8'h84;
    localparam logic [7:0] STAT       = 8'hD7;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid;
    logic [2:0] req_op;
    logic [8:0] req_page, req_byte;
    logic [7:0] req_wdata;
    logic req_ready, done, err_timeout, err_density;
    logic [7:0] rd_data;
    logic spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dflash_cmd_ctrl #(
        .DIV_HALF(DIV), .SCK_IDLE_HIGH(1'b0), .CS_GAP(GAP), .POLL_LIMIT(PLIM),
        .OPC_PROG(PROG), .OPC_BUF_WR(BUFWR), .OPC_STATUS(STAT), .DENSITY_CODE(3'b001)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_page(req_page), .req_byte(req_byte), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .err_timeout(err_timeout), .err_density(err_density),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    int         m_cnt = 0;
    logic       m_bit [0:95];
    int         m_busy = 0;
    int         m_stall = 0;
    logic [2:0] m_density = 3'b001;
    logic [7:0] m_buf [0:263];
    logic [7:0] m_mem [int];
    int         frame_cnt = 0;
    int         hi_clk = 0;
    int         fr_opc [int];
    int         fr_nb  [int];
    int         fr_addr[int];
    int         fr_hi  [int];

    function automatic logic [31:0] fld(input int s, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r = {r[30:0], m_bit[s+i]};
        return r;
    endfunction

    function automatic logic [7:0] mbyte(input int idx);
        return m_mem.exists(idx) ? m_mem[idx] : 8'hFF;
    endfunction

    function automatic logic out_bit(input int idx);
        logic [7:0] opc, b;
        int pg, by;
        if (idx < 8) return 1'b0;
        opc = fld(0, 8);
        if (opc == STAT) begin
            b = {(m_busy == 0), 1'b0, m_density, 3'b000};
            return b[7 - ((idx - 8) % 8)];
        end
        if (idx < 40) return 1'b0;
        pg = int'(fld(14, 9));
        by = int'(fld(23, 9));
        if (by > 263) by = 263;
        if (opc == 8'h54) begin
            b = m_buf[by];
            return b[7 - ((idx - 40) % 8)];
        end
        if (opc == 8'h52 && idx >= 64) begin
            b = mbyte(pg * 264 + by);
            return b[7 - ((idx - 64) % 8)];
        end
        return 1'b0;
    endfunction

    always @(negedge spi_cs_n) begin
        m_cnt  = 0;
        hi_clk = 0;
        spi_miso = 1'b0;
    end

    always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
        if (m_cnt < 96) m_bit[m_cnt] = spi_mosi;
        m_cnt++;
    end

    always @(negedge spi_sck) if (spi_cs_n === 1'b0) spi_miso = out_bit(m_cnt);

    always @(negedge clk) if (spi_cs_n === 1'b0 && spi_sck === 1'b1) hi_clk++;

    always @(posedge spi_cs_n) if (m_cnt > 0) begin
        logic [7:0] opc;
        int pg, by;
        opc = fld(0, 8);
        fr_opc[frame_cnt] = int'(opc);
        fr_nb[frame_cnt]  = m_cnt;
        fr_addr[frame_cnt] = (m_cnt >= 32) ? int'(fld(8, 24)) : -1;
        fr_hi[frame_cnt]  = hi_clk;
        pg = int'(fld(14, 9));
        by = int'(fld(23, 9));
        if (opc == STAT) begin
            if (m_busy > 0) m_busy--;
        end else if (opc == BUFWR && m_cnt >= 40) begin
            if (by < 264) m_buf[by] = fld(32, 8);
        end else if (opc == PROG) begin
            for (int i = 0; i < 264; i++) m_mem[pg*264+i] = m_buf[i];
            m_busy = m_stall;
        end else if (opc == 8'h53) begin
            for (int i = 0; i < 264; i++) m_buf[i] = mbyte(pg*264+i);
            m_busy = m_stall;
        end else if (opc == 8'h81) begin
            for (int i = 0; i < 264; i++) m_mem[pg*264+i] = 8'hFF;
            m_busy = m_stall;
        end else if (opc == 8'h50) begin
            for (int p = (pg & ~7); p < (pg & ~7) + 8; p++)
                for (int i = 0; i < 264; i++) m_mem[p*264+i] = 8'hFF;
            m_busy = m_stall;
        end
        m_cnt = 0;
        frame_cnt++;
    end

    // ---------------- bus monitors ----------------
    int  hi_run = 0;
    int  gap_min = 1000;
    bit  seen_low = 0;
    int  idle_bad = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            hi_run = 0; seen_low = 0;
        end else begin
            if (spi_cs_n) hi_run++;
            else begin
                if (seen_low && hi_run > 0 && hi_run < gap_min) gap_min = hi_run;
                hi_run = 0; seen_low = 1;
            end
            if (spi_cs_n && spi_sck !== 1'b0) idle_bad++;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual %0d expected <150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- reference shadow ----------------
    logic [7:0] exp_buf [0:263];
    logic [7:0] exp_mem [int];

    function automatic logic [7:0] sget(input int pg, input int by);
        return exp_mem.exists(pg*264+by) ? exp_mem[pg*264+by] : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_opc(input logic [2:0] op);
        case (op)
            3'd0: return 8'h52;
            3'd1: return 8'h54;
            3'd2: return BUFWR;
            3'd3: return 8'h53;
            3'd4: return PROG;
            3'd5: return 8'h81;
            3'd6: return 8'h50;
            default: return STAT;
        endcase
    endfunction

    function automatic int exp_nb(input logic [2:0] op);
        case (op)
            3'd0: return 72;
            3'd1: return 48;
            3'd2: return 40;
            3'd7: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic bit is_timed(input logic [2:0] op);
        return (op >= 3'd3 && op <= 3'd6);
    endfunction

    int r_first, r_frames;

    task automatic run_op(input logic [2:0] op, input int pg, input int by,
                          input logic [7:0] wd, input int stall, input bit spam);
        int f0;
        m_stall = stall;
        while (!req_ready) @(negedge clk);
        f0 = frame_cnt;
        req_valid = 1'b1; req_op = op; req_page = 9'(pg); req_byte = 9'(by); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) begin
            if (spam) begin req_valid = 1'b1; req_op = 3'd6; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        r_first = f0;
        r_frames = frame_cnt - f0;
        @(negedge clk);
        chk(done == 1'b0, "R12 done width", done, 0);
    endtask

    task automatic do_op(input logic [2:0] op, input int pg, input int by,
                         input logic [7:0] wd, input int stall);
        int  exp_frames;
        bit  exp_to;
        logic [7:0] exp_rd;
        logic [7:0] saved_rd;
        exp_rd = 8'h00;
        if (op == 3'd0) exp_rd = sget(pg, by);
        if (op == 3'd1) exp_rd = exp_buf[by];
        if (op == 3'd7) exp_rd = {(m_busy == 0), 1'b0, m_density, 3'b000};
        saved_rd = rd_data;
        run_op(op, pg, by, wd, stall, 1'b0);
        exp_to = is_timed(op) && (stall + 1 > PLIM);
        exp_frames = !is_timed(op) ? 1 : (exp_to ? 1 + PLIM : stall + 2);
        chk(fr_opc[r_first] == int'(exp_opc(op)), "R3 opcode", fr_opc[r_first], exp_opc(op));
        chk(fr_nb[r_first] == exp_nb(op) && (fr_nb[r_first] % 8) == 0, "R10 frame bits",
            fr_nb[r_first], exp_nb(op));
        chk(fr_hi[r_first] == exp_nb(op) * DIV, "R10 sck high time", fr_hi[r_first], exp_nb(op) * DIV);
        if (op != 3'd7)
            chk(fr_addr[r_first] == int'({6'b0, 9'(pg), 9'(by)}), "R3 address",
                fr_addr[r_first], {6'b0, 9'(pg), 9'(by)});
        if (op == 3'd0) chk(rd_data == exp_rd, "R4 page read data", rd_data, exp_rd);
        if (op == 3'd1) chk(rd_data == exp_rd, "R5 buffer read data", rd_data, exp_rd);
        if (op == 3'd7) chk(rd_data == exp_rd, "R13 status data", rd_data, exp_rd);
        if (op == 3'd2 || is_timed(op))
            chk(rd_data == saved_rd, "R6 rd_data kept", rd_data, saved_rd);
        chk(r_frames == exp_frames, "R7 frame count", r_frames, exp_frames);
        if (is_timed(op))
            chk(fr_opc[r_first+1] == int'(STAT) && fr_nb[r_first+1] == 16, "R7 poll frame",
                fr_opc[r_first+1], STAT);
        chk(err_timeout == exp_to, "R8 timeout flag", err_timeout, exp_to);
        case (op)
            3'd2: exp_buf[by] = wd;
            3'd3: for (int i = 0; i < 264; i++) exp_buf[i] = sget(pg, i);
            3'd4: for (int i = 0; i < 264; i++) exp_mem[pg*264+i] = exp_buf[i];
            3'd5: for (int i = 0; i < 264; i++) exp_mem[pg*264+i] = 8'hFF;
            3'd6: for (int p = (pg & ~7); p < (pg & ~7) + 8; p++)
                      for (int i = 0; i < 264; i++) exp_mem[p*264+i] = 8'hFF;
            default: ;
        endcase
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 264; i++) begin m_buf[i] = 8'hFF; exp_buf[i] = 8'hFF; end
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_page = '0; req_byte = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 reset bus idle", {spi_cs_n, spi_sck}, 2'b10);
        chk(req_ready == 1'b0 && done == 1'b0, "R1 reset handshake", {req_ready, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 not ready before boot frame", req_ready, 0);
        while (!req_ready) @(negedge clk);
        chk(frame_cnt == 1 && fr_opc[0] == int'(STAT) && fr_nb[0] == 16, "R1 boot status frame",
            fr_opc[0], STAT);
        chk(err_density == 1'b0, "R2 density ok", err_density, 0);

        // directed corners
        do_op(3'd2, 0, 0, 8'hA5, 0);
        do_op(3'd2, 0, 263, 8'h5A, 0);
        do_op(3'd1, 0, 263, 8'h00, 0);
        do_op(3'd1, 0, 0, 8'h00, 0);
        do_op(3'd4, 511, 0, 8'h00, 2);
        do_op(3'd0, 511, 263, 8'h00, 0);
        do_op(3'd0, 511, 0, 8'h00, 0);
        do_op(3'd3, 511, 0, 8'h00, 0);
        do_op(3'd5, 511, 0, 8'h00, 1);
        do_op(3'd0, 511, 0, 8'h00, 0);
        do_op(3'd7, 0, 0, 8'h00, 0);

        // busy request ignored
        begin
            int f0;
            f0 = frame_cnt;
            run_op(3'd0, 3, 7, 8'h00, 0, 1'b1);
            chk(r_frames == 1, "R11 request during busy ignored", r_frames, 1);
            repeat (20) @(negedge clk);
            chk(frame_cnt == f0 + 1, "R11 no late frame", frame_cnt - f0, 1);
        end

        // timeout then recovery
        do_op(3'd5, 40, 0, 8'h00, 100);
        m_busy = 0;
        do_op(3'd7, 0, 0, 8'h00, 0);
        chk(err_timeout == 1'b0, "R8 cleared on accept", err_timeout, 0);

        // random mix
        for (int n = 0; n < 30; n++) begin
            logic [2:0] op;
            int pg, by, st;
            op = 3'($urandom_range(0, 7));
            pg = $urandom_range(0, 511);
            by = $urandom_range(0, 263);
            st = $urandom_range(0, 3);
            do_op(op, pg, by, 8'($urandom_range(0, 255)), st);
        end

        chk(gap_min >= GAP, "R9 chip-select gap", gap_min, GAP);
        chk(idle_bad == 0, "R10 sck idle level", idle_bad, 0);

        // wrong density at boot
        m_density = 3'b010;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk(err_density == 1'b1, "R2 density mismatch", err_density, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule